// File: doc/BRIEF.md
# Panel Trap Entry Controller

This block decides when a 12-bit processor with a separate front-panel (control) mode leaves normal execution and enters panel mode through a trap. It keeps two bits of state. One is a pending-trap flag, set by the panel-request instructions and cleared by the panel status-read and panel-exit instructions. The other is a flip-flop that records whether the processor is in panel mode. Instruction decoding happens elsewhere. The block receives one strobe per decoded instruction of interest.

At every instruction boundary, which a fetch strobe marks, the block checks the pending flag against the interrupt-delay and interrupt-inhibit flags and against the current mode. If a trap is due, it runs a two-cycle sequence. In the first cycle it writes the return PC to the save location at address 0000 octal. In the second cycle it loads the PC with the vector 7777 octal and pulses an acknowledge. Panel mode begins on the cycle after that. A parameter removes the whole panel extension. With the extension removed, no flag is ever set and no trap is ever taken.

Top module: `pnl_trap_ctrl`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, `trap_pend`, `panel_mode`, `mem_we`, `pc_load` and `trap_ack` are all 0.
- R2: Outside panel mode, a high bit on any of the four `req_strb` lines (panel requests 0 to 3) sets `trap_pend`, and the new value is visible in the following cycle.
- R3: In panel mode, `req_strb` has no effect on `trap_pend`. When no set or clear condition applies, `trap_pend` holds its value.
- R4: `rd_status_strb` clears `trap_pend` only in panel mode. Outside panel mode it has no effect.
- R5: `exit_strb` in panel mode clears both `trap_pend` and `panel_mode`. Outside panel mode it has no effect.
- R6: A trap starts only on a cycle where all of these hold: `fetch_bnd` is 1, `trap_pend` is 1, `intr_delay` is 0, `intr_inhibit` is 0, `panel_mode` is 0, and no trap sequence is running.
- R7: In the cycle after the trap starts, `mem_we` is 1, `mem_addr` is 0, and `mem_wdata` holds the `pc_in` value sampled at the boundary, even if `pc_in` has since changed.
- R8: In the cycle after the save, `pc_load` and `trap_ack` are 1 and `pc_value` is 7777 octal (all ones). From the next cycle on, `panel_mode` is 1.
- R9: A boundary with `intr_delay` or `intr_inhibit` high takes no trap, and `trap_pend` stays set.
- R10: A request strobe on the same cycle as a boundary does not trigger that boundary. The trap is taken at the next boundary.
- R11: With `ENABLE_PANEL` = 0, `trap_pend`, `panel_mode`, `mem_we` and `pc_load` stay 0 for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_strb | input | NUM_REQ | Decoded panel-request instruction strobes |
| rd_status_strb | input | 1 | Decoded panel status-read strobe |
| exit_strb | input | 1 | Decoded panel-exit strobe |
| intr_delay | input | 1 | Interrupt-delay flag from the core |
| intr_inhibit | input | 1 | Interrupt-inhibit flag from the core |
| fetch_bnd | input | 1 | High on the cycle before an instruction fetch |
| pc_in | input | PC_W | Current PC, which is the return address |
| mem_we | output | 1 | Memory write for the PC save |
| mem_addr | output | PC_W | Address of the save write |
| mem_wdata | output | PC_W | Saved return PC |
| pc_load | output | 1 | Load the PC with the vector |
| pc_value | output | PC_W | Vector value |
| trap_ack | output | 1 | Pulse in the vector cycle |
| panel_mode | output | 1 | Panel-mode flip-flop |
| trap_pend | output | 1 | Pending-trap flag |

## Verification
The hardest states to reach are the ones that exist only inside panel mode, because a trap is the only way in. The stimulus first arms the flag and then completes a full save-and-vector sequence. Only after that does it apply request strobes that must be ignored, followed by the status-read and exit strobes that must clear. The same-cycle race between a request and a boundary is driven on purpose, and so is a reset that arrives in the middle of the save cycle.

// File: rtl/pnl_trap_pkg.sv
package pnl_trap_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SAVE = 2'd1,
      SEQ_VEC  = 2'd2
   } seq_state_t;
endpackage

// File: rtl/pnl_trap_flag.sv
module pnl_trap_flag #(
   parameter int NUM_REQ = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req,
   input  logic               rd_status,
   input  logic               ex,
   input  logic               in_panel,
   output logic               pend
);
   logic set_c, clr_c;

   // requests count only in normal mode, clears only in panel mode
   assign set_c = (|req) & ~in_panel;
   assign clr_c = (rd_status | ex) & in_panel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend <= 1'b0;
      else if (set_c) pend <= 1'b1;
      else if (clr_c) pend <= 1'b0;
   end
endmodule

// File: rtl/pnl_mode_ff.sv
module pnl_mode_ff (
   input  logic clk,
   input  logic rst_n,
   input  logic enter,
   input  logic ex,
   output logic in_panel
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               in_panel <= 1'b0;
      else if (enter)           in_panel <= 1'b1;
      else if (ex && in_panel)  in_panel <= 1'b0;
   end
endmodule

// File: rtl/pnl_trap_seq.sv
module pnl_trap_seq
   import pnl_trap_pkg::*;
#(
   parameter int              PC_W      = 12,
   parameter logic [PC_W-1:0] SAVE_ADDR = '0,
   parameter logic [PC_W-1:0] VEC_ADDR  = '1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            fetch,
   input  logic            pend,
   input  logic            delay,
   input  logic            inhibit,
   input  logic            in_panel,
   input  logic [PC_W-1:0] pc_in,
   output logic            mem_we,
   output logic [PC_W-1:0] mem_addr,
   output logic [PC_W-1:0] mem_wdata,
   output logic            pc_load,
   output logic [PC_W-1:0] pc_value,
   output logic            ack,
   output logic            enter
);
   seq_state_t      state_q, state_d;
   logic [PC_W-1:0] ret_pc_q;
   logic            take;

   assign take = fetch & pend & ~delay & ~inhibit & ~in_panel
                 & (state_q == SEQ_IDLE);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SEQ_IDLE: if (take) state_d = SEQ_SAVE;
         SEQ_SAVE: state_d = SEQ_VEC;
         SEQ_VEC:  state_d = SEQ_IDLE;
         default:  state_d = SEQ_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         ret_pc_q <= '0;
      end else begin
         state_q <= state_d;
         if (take) ret_pc_q <= pc_in;
      end
   end

   assign mem_we    = (state_q == SEQ_SAVE);
   assign mem_addr  = SAVE_ADDR;
   assign mem_wdata = ret_pc_q;
   assign pc_load   = (state_q == SEQ_VEC);
   assign pc_value  = VEC_ADDR;
   assign ack       = (state_q == SEQ_VEC);
   assign enter     = (state_q == SEQ_VEC);
endmodule

// File: rtl/pnl_trap_ctrl.sv
module pnl_trap_ctrl #(
   parameter bit              ENABLE_PANEL = 1'b1,
   parameter int              PC_W         = 12,
   parameter int              NUM_REQ      = 4,
   parameter logic [PC_W-1:0] SAVE_ADDR    = '0,
   parameter logic [PC_W-1:0] VEC_ADDR     = '1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_REQ-1:0] req_strb,
   input  logic               rd_status_strb,
   input  logic               exit_strb,
   input  logic               intr_delay,
   input  logic               intr_inhibit,
   input  logic               fetch_bnd,
   input  logic [PC_W-1:0]    pc_in,
   output logic               mem_we,
   output logic [PC_W-1:0]    mem_addr,
   output logic [PC_W-1:0]    mem_wdata,
   output logic               pc_load,
   output logic [PC_W-1:0]    pc_value,
   output logic               trap_ack,
   output logic               panel_mode,
   output logic               trap_pend
);
   localparam int MIN_PC_W = 2;

   if (PC_W < MIN_PC_W) begin : g_bad_pcw
      $error("pnl_trap_ctrl: PC_W must be at least %0d", MIN_PC_W);
   end
   if (NUM_REQ < 1) begin : g_bad_req
      $error("pnl_trap_ctrl: NUM_REQ must be at least 1");
   end
   if (SAVE_ADDR == VEC_ADDR) begin : g_bad_addr
      $error("pnl_trap_ctrl: save and vector addresses must differ");
   end

   if (ENABLE_PANEL) begin : g_panel
      logic enter_w;

      pnl_trap_flag #(.NUM_REQ(NUM_REQ)) flag_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .req       (req_strb),
         .rd_status (rd_status_strb),
         .ex        (exit_strb),
         .in_panel  (panel_mode),
         .pend      (trap_pend)
      );

      pnl_mode_ff mode_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .enter    (enter_w),
         .ex       (exit_strb),
         .in_panel (panel_mode)
      );

      pnl_trap_seq #(
         .PC_W      (PC_W),
         .SAVE_ADDR (SAVE_ADDR),
         .VEC_ADDR  (VEC_ADDR)
      ) seq_i (
         .clk       (clk),
         .rst_n     (rst_n),
         .fetch     (fetch_bnd),
         .pend      (trap_pend),
         .delay     (intr_delay),
         .inhibit   (intr_inhibit),
         .in_panel  (panel_mode),
         .pc_in     (pc_in),
         .mem_we    (mem_we),
         .mem_addr  (mem_addr),
         .mem_wdata (mem_wdata),
         .pc_load   (pc_load),
         .pc_value  (pc_value),
         .ack       (trap_ack),
         .enter     (enter_w)
      );
   end else begin : g_no_panel
      assign trap_pend  = 1'b0;
      assign panel_mode = 1'b0;
      assign mem_we     = 1'b0;
      assign mem_addr   = SAVE_ADDR;
      assign mem_wdata  = '0;
      assign pc_load    = 1'b0;
      assign pc_value   = VEC_ADDR;
      assign trap_ack   = 1'b0;
   end
endmodule

// File: rtl/pnl_trap_ctrl_chk.sv
module pnl_trap_ctrl_chk #(
   parameter bit EN      = 1'b1,
   parameter int PC_W    = 12,
   parameter int NUM_REQ = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_REQ-1:0] req_strb,
   input logic               rd_status_strb,
   input logic               exit_strb,
   input logic               intr_delay,
   input logic               intr_inhibit,
   input logic               fetch_bnd,
   input logic [PC_W-1:0]    pc_in,
   input logic               mem_we,
   input logic [PC_W-1:0]    mem_addr,
   input logic [PC_W-1:0]    mem_wdata,
   input logic               pc_load,
   input logic [PC_W-1:0]    pc_value,
   input logic               trap_ack,
   input logic               panel_mode,
   input logic               trap_pend
);
   if (EN) begin : g_on
      assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (!panel_mode && |req_strb) |=> trap_pend);

      assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (!(|req_strb && !panel_mode) && !((rd_status_strb || exit_strb) && panel_mode))
         |=> $stable(trap_pend));

      assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (panel_mode && rd_status_strb) |=> !trap_pend);

      assert_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (panel_mode && exit_strb) |=> (!panel_mode && !trap_pend));

      assert_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mem_we) |-> $past(fetch_bnd && trap_pend && !intr_delay
                                  && !intr_inhibit && !panel_mode));

      assert_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |-> (mem_addr == '0 && !pc_load));

      assert_save_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
         mem_we |=> (pc_load && trap_ack && !mem_we));

      assert_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pc_load |-> (pc_value == '1 && trap_ack));

      assert_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
         pc_load |=> (panel_mode && !pc_load));

      assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (fetch_bnd && (intr_delay || intr_inhibit) && !mem_we && !pc_load)
         |=> !mem_we);
   end else begin : g_off
      assert_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (!trap_pend && !panel_mode && !mem_we && !pc_load));
   end
endmodule

bind pnl_trap_ctrl pnl_trap_ctrl_chk #(
   .EN      (ENABLE_PANEL),
   .PC_W    (PC_W),
   .NUM_REQ (NUM_REQ)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .req_strb       (req_strb),
   .rd_status_strb (rd_status_strb),
   .exit_strb      (exit_strb),
   .intr_delay     (intr_delay),
   .intr_inhibit   (intr_inhibit),
   .fetch_bnd      (fetch_bnd),
   .pc_in          (pc_in),
   .mem_we         (mem_we),
   .mem_addr       (mem_addr),
   .mem_wdata      (mem_wdata),
   .pc_load        (pc_load),
   .pc_value       (pc_value),
   .trap_ack       (trap_ack),
   .panel_mode     (panel_mode),
   .trap_pend      (trap_pend)
);

// File: tb/pnl_trap_ctrl_tb.sv
module pnl_trap_ctrl_tb_top;
   localparam int PC_W    = 12;
   localparam int NUM_REQ = 4;
   localparam int NROWS   = 18;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NUM_REQ-1:0] req_strb = '0;
   logic               rd_status_strb = 1'b0;
   logic               exit_strb = 1'b0;
   logic               intr_delay = 1'b0;
   logic               intr_inhibit = 1'b0;
   logic               fetch_bnd = 1'b0;
   logic [PC_W-1:0]    pc_in = '0;

   logic               mem_we, pc_load, trap_ack, panel_mode, trap_pend;
   logic [PC_W-1:0]    mem_addr, mem_wdata, pc_value;
   logic               o_mem_we, o_pc_load, o_trap_ack, o_panel_mode, o_trap_pend;
   logic [PC_W-1:0]    o_mem_addr, o_mem_wdata, o_pc_value;

   int errors = 0;
   int checks = 0;
   bit off_seen = 1'b0;

   always #5 clk = ~clk;

   pnl_trap_ctrl #(.ENABLE_PANEL(1'b1), .PC_W(PC_W), .NUM_REQ(NUM_REQ)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_strb(req_strb),
      .rd_status_strb(rd_status_strb), .exit_strb(exit_strb),
      .intr_delay(intr_delay), .intr_inhibit(intr_inhibit),
      .fetch_bnd(fetch_bnd), .pc_in(pc_in),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .pc_load(pc_load), .pc_value(pc_value), .trap_ack(trap_ack),
      .panel_mode(panel_mode), .trap_pend(trap_pend));

   pnl_trap_ctrl #(.ENABLE_PANEL(1'b0), .PC_W(PC_W), .NUM_REQ(NUM_REQ)) dut_off_i (
      .clk(clk), .rst_n(rst_n), .req_strb(req_strb),
      .rd_status_strb(rd_status_strb), .exit_strb(exit_strb),
      .intr_delay(intr_delay), .intr_inhibit(intr_inhibit),
      .fetch_bnd(fetch_bnd), .pc_in(pc_in),
      .mem_we(o_mem_we), .mem_addr(o_mem_addr), .mem_wdata(o_mem_wdata),
      .pc_load(o_pc_load), .pc_value(o_pc_value), .trap_ack(o_trap_ack),
      .panel_mode(o_panel_mode), .trap_pend(o_trap_pend));

   // sampled away from the active edge
   always @(negedge clk)
      if (rst_n && (o_trap_pend || o_panel_mode || o_mem_we || o_pc_load))
         off_seen = 1'b1;

   // row: req[11:8] rd[7] ex[6] dly[5] inh[4] fb[3] | exp_trap[2] exp_pend[1] exp_mode[0]
   localparam logic [11:0] TBL [NROWS] = '{
      12'b0000_1_0_0_0_0_000, // 0  R4 read-status outside panel mode ignored
      12'b0000_0_1_0_0_0_000, // 1  R5 exit outside panel mode ignored
      12'b0000_0_0_0_0_1_000, // 2  R6 boundary with no pending trap
      12'b0001_0_0_0_0_0_010, // 3  R2 request 0 sets flag
      12'b0000_0_0_1_0_1_010, // 4  R9 interrupt delay blocks
      12'b0000_0_0_0_1_1_010, // 5  R9 interrupt inhibit blocks
      12'b0000_0_0_0_0_1_111, // 6  R6 trap taken
      12'b1111_0_0_0_0_1_011, // 7  R3 requests in panel mode ignored
      12'b0000_1_0_0_0_0_001, // 8  R4 read-status clears in panel mode
      12'b0100_0_0_0_0_0_001, // 9  R3 request 2 in panel mode ignored
      12'b0000_0_1_0_0_0_000, // 10 R5 exit leaves panel mode
      12'b1000_0_0_0_0_1_010, // 11 R10 request and boundary same cycle
      12'b0000_0_0_0_0_1_111, // 12 R10 trap at next boundary
      12'b0000_0_1_0_0_0_000, // 13 R5 exit clears flag and mode
      12'b0010_0_0_0_0_0_010, // 14 R2 request 1 sets flag
      12'b0000_0_0_0_0_1_111, // 15 R6 trap taken again
      12'b0000_1_1_0_0_0_000, // 16 R4 read-status and exit together
      12'b0001_1_1_0_0_0_010  // 17 R2 request wins outside panel mode
   };

   function automatic string row_tag(input int i);
      case (i)
         0, 8, 16:  return "R4";
         1, 10, 13: return "R5";
         3, 14, 17: return "R2";
         4, 5:      return "R9";
         7, 9:      return "R3";
         11, 12:    return "R10";
         default:   return "R6";
      endcase
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0o expected=%0o", tag, what, act, exp);
      end
   endtask

   task automatic clear_inputs();
      req_strb = '0; rd_status_strb = 1'b0; exit_strb = 1'b0;
      intr_delay = 1'b0; intr_inhibit = 1'b0; fetch_bnd = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : stim
      int traps;
      // R1 reset state
      #1;
      check("R1", "pend in reset", {11'd0, trap_pend}, 12'd0);
      check("R1", "mode in reset", {11'd0, panel_mode}, 12'd0);
      check("R1", "outputs in reset", {9'd0, mem_we, pc_load, trap_ack}, 12'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROWS; i++) begin
         req_strb       = TBL[i][11:8];
         rd_status_strb = TBL[i][7];
         exit_strb      = TBL[i][6];
         intr_delay     = TBL[i][5];
         intr_inhibit   = TBL[i][4];
         fetch_bnd      = TBL[i][3];
         pc_in          = 12'(i * 3 + 1);
         traps = 0;
         @(negedge clk);
         clear_inputs();
         for (int k = 0; k < 3; k++) begin
            if (mem_we) traps++;
            if (k < 2) @(negedge clk);
         end
         check(row_tag(i), $sformatf("row %0d trap count", i), 12'(traps), {11'd0, TBL[i][2]});
         check(row_tag(i), $sformatf("row %0d pend", i), {11'd0, trap_pend}, {11'd0, TBL[i][1]});
         check(row_tag(i), $sformatf("row %0d mode", i), {11'd0, panel_mode}, {11'd0, TBL[i][0]});
      end

      // R7/R8 exact cycles: flag is set, mode clear after last row
      pc_in = 12'o1234;
      fetch_bnd = 1'b1;
      @(negedge clk);
      clear_inputs();
      check("R7", "save we", {11'd0, mem_we}, 12'd1);
      check("R7", "save addr", mem_addr, 12'o0000);
      check("R7", "save data", mem_wdata, 12'o1234);
      check("R7", "no load in save", {11'd0, pc_load}, 12'd0);
      pc_in = 12'o5555;
      @(negedge clk);
      check("R8", "vector load", {11'd0, pc_load}, 12'd1);
      check("R8", "vector ack", {11'd0, trap_ack}, 12'd1);
      check("R8", "vector value", pc_value, 12'o7777);
      check("R8", "we off in vector", {11'd0, mem_we}, 12'd0);
      check("R8", "mode not yet", {11'd0, panel_mode}, 12'd0);
      @(negedge clk);
      check("R8", "mode entered", {11'd0, panel_mode}, 12'd1);
      check("R8", "load dropped", {11'd0, pc_load}, 12'd0);

      // leave panel mode, arm again, reset in the save cycle
      exit_strb = 1'b1;
      @(negedge clk);
      clear_inputs();
      req_strb = 4'b0100;
      @(negedge clk);
      clear_inputs();
      fetch_bnd = 1'b1;
      @(negedge clk);
      clear_inputs();
      check("R7", "save before reset", {11'd0, mem_we}, 12'd1);
      rst_n = 1'b0;
      #1;
      check("R1", "async reset we", {11'd0, mem_we}, 12'd0);
      check("R1", "async reset pend", {11'd0, trap_pend}, 12'd0);
      check("R1", "async reset mode", {11'd0, panel_mode}, 12'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check("R1", "no resumed load", {11'd0, pc_load}, 12'd0);

      // R11 disabled instance saw the whole stimulus
      check("R11", "disabled instance stayed idle", {11'd0, off_seen}, 12'd0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule